// File: doc/BRIEF.md
# Register-Offset Word Store Decode and Address Unit

This block accepts one store-word instruction per cycle in any of three encodings: a 32-bit conditional format, a 16-bit compact format and a 32-bit compact format built from two halfwords. An input selects the format. The block extracts the base, offset and source register numbers, the pre/post-index choice, the add/subtract choice, the writeback enable and the shift that applies to the offset register. It drives those register numbers onto three read-index outputs and takes the register values back in the same cycle. It then shifts the offset value, forms the effective address and registers a one-word memory write request and a base-register writeback request.

Encodings that do not match, encodings that belong to the unprivileged store variant, and register combinations that are not allowed each raise their own flag. A flagged instruction is not executed: no memory write and no writeback are issued. Condition evaluation, the register file and the memory are outside the block.

Top module: `stw_regoff_unit`

## Requirements
- R1: All outputs except the read indices are registered. They show the result of an instruction presented with `in_valid` high exactly one clock edge later, and they are all zero during and after reset and in the cycle after `in_valid` is low.
- R2: With `fmt_sel`=0 (32-bit conditional format), the instruction is valid only when bits 27:25 are 011, bits 22, 20 and 4 are 0 and bits 31:28 are not 1111; otherwise `flag_undef` is raised. The fields are: pre-index = bit 24, add = bit 23, W = bit 21, base = bits 19:16, source = bits 15:12, shift amount = bits 11:7, shift kind = bits 6:5, offset register = bits 3:0. Writeback is enabled when bit 24 is 0 or bit 21 is 1.
- R3: In that format, bit 24 = 0 with bit 21 = 1 raises `flag_alt` and issues no write.
- R4: In that format, offset register 15, or writeback enabled with base register 15 or base equal to source, raises `flag_unpred` and issues neither write.
- R5: Shift kind codes are 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right, applied by a nonzero amount of 1 to 31.
- R6: With amount 0, left logical is no shift, right logical yields zero, right arithmetic fills every bit with the sign bit, and rotate right becomes a one-bit rotate through `carry_in` (carry into bit 31, bits 31:1 move down).
- R7: The offset address is base plus shifted offset when add is set, base minus it otherwise. The memory address is the offset address with pre-index set and the base value without. With writeback, `wb_idx` is the base register and `wb_val` the offset address.
- R8: When the source register is 15, the write data is `pc_store_val` instead of the register read.
- R9: With `fmt_sel`=1, bits 15:9 must be 0101000 (else `flag_undef`); offset register = bits 8:6, base = bits 5:3, source = bits 2:0, each extended to 4 bits; add, pre-index, no shift, no writeback; bits 31:16 are ignored.
- R10: With `fmt_sel`=2, bits 31:20 must be 1111_1000_0100 and bits 11:6 zero (else `flag_undef`); base = bits 19:16, source = bits 15:12, left shift by bits 5:4, offset register = bits 3:0; add, pre-index, no writeback.
- R11: With `fmt_sel`=2, base 1111 raises `flag_undef`; source 15 or offset register 15 raises `flag_unpred`; neither writes.
- R12: `fmt_sel`=3 raises `flag_undef`.
- R13: At most one flag is high; an encoding that fails to match raises only `flag_undef` whatever its register fields hold.
- R14: `rd_base_idx`, `rd_ofs_idx` and `rd_src_idx` follow the decoded register numbers combinationally in the cycle the instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| fmt_sel | input | 2 | Encoding select: 0 conditional 32-bit, 1 16-bit, 2 halfword pair |
| insn | input | 32 | Instruction bits (16-bit form in 15:0, pair with first halfword in 31:16) |
| carry_in | input | 1 | Carry used by the zero-amount rotate |
| pc_store_val | input | XLEN | Value stored when the source register is 15 |
| rd_base_idx | output | 4 | Read index for the base register |
| rd_ofs_idx | output | 4 | Read index for the offset register |
| rd_src_idx | output | 4 | Read index for the source register |
| rd_base_val | input | XLEN | Base register value |
| rd_ofs_val | input | XLEN | Offset register value |
| rd_src_val | input | XLEN | Source register value |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | XLEN | Memory word address |
| mem_wdata | output | XLEN | Memory write data |
| wb_we | output | 1 | Base writeback request |
| wb_idx | output | 4 | Register written back |
| wb_val | output | XLEN | Writeback value |
| flag_undef | output | 1 | Encoding not recognised |
| flag_alt | output | 1 | Unprivileged variant, not executed |
| flag_unpred | output | 1 | Illegal register combination, not executed |

## Verification
The read indices are combinational, so the bench checks them one nanosecond after driving an instruction on a falling edge. Every other result passes one register: inputs change on a falling edge, the next rising edge captures them, and the bench compares at the falling edge after that, which is where each vector's expected write, writeback and flag values are due. A dropped `in_valid` and a reset held across a valid instruction are each checked at that same falling edge, one edge after the cause.

// File: rtl/stw_regoff_pkg.sv
package stw_regoff_pkg;

  localparam int INSN_W  = 32;
  localparam int RIX_W   = 4;
  localparam int SHAMT_W = 5;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shkind_e;

  typedef enum logic [1:0] {
    FMT_WIDE   = 2'd0,
    FMT_NARROW = 2'd1,
    FMT_PAIR   = 2'd2
  } fmt_e;

  typedef struct packed {
    logic                 bad;
    logic                 alt;
    logic                 unpred;
    logic [RIX_W-1:0]     base;
    logic [RIX_W-1:0]     ofs;
    logic [RIX_W-1:0]     src;
    logic                 pre;
    logic                 up;
    logic                 wb;
    shkind_e              kind;
    logic [SHAMT_W-1:0]   amt;
  } dec_t;

  localparam logic [RIX_W-1:0] PC_IX = '1;

endpackage

// File: rtl/stw_dec_wide.sv
module stw_dec_wide
  import stw_regoff_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              d
);
  logic p_bit, u_bit, w_bit, shape_ok, cond_ok, wbk;
  logic [RIX_W-1:0] n_ix, t_ix, m_ix;

  always_comb begin
    p_bit    = insn[24];
    u_bit    = insn[23];
    w_bit    = insn[21];
    n_ix     = insn[19:16];
    t_ix     = insn[15:12];
    m_ix     = insn[3:0];
    shape_ok = (insn[27:25] == 3'b011) && !insn[22] && !insn[20] && !insn[4];
    cond_ok  = (insn[31:28] != 4'hF);
    wbk      = !p_bit || w_bit;

    d        = '0;
    d.bad    = !(shape_ok && cond_ok);
    d.alt    = !d.bad && !p_bit && w_bit;
    d.unpred = !d.bad && !d.alt &&
               ((m_ix == PC_IX) || (wbk && ((n_ix == PC_IX) || (n_ix == t_ix))));
    d.base   = n_ix;
    d.ofs    = m_ix;
    d.src    = t_ix;
    d.pre    = p_bit;
    d.up     = u_bit;
    d.wb     = wbk;
    d.kind   = shkind_e'(insn[6:5]);
    d.amt    = insn[11:7];
  end
endmodule

// File: rtl/stw_dec_narrow.sv
module stw_dec_narrow
  import stw_regoff_pkg::*;
(
  input  logic [15:0] hw,
  output dec_t        d
);
  always_comb begin
    d        = '0;
    d.bad    = (hw[15:9] != 7'b0101000);
    d.base   = {1'b0, hw[5:3]};
    d.ofs    = {1'b0, hw[8:6]};
    d.src    = {1'b0, hw[2:0]};
    d.pre    = 1'b1;
    d.up     = 1'b1;
    d.wb     = 1'b0;
    d.kind   = SH_LSL;
    d.amt    = '0;
  end
endmodule

// File: rtl/stw_dec_pair.sv
module stw_dec_pair
  import stw_regoff_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              d
);
  logic [15:0] hw_hi, hw_lo;
  logic        shape_ok;

  always_comb begin
    hw_hi    = insn[31:16];
    hw_lo    = insn[15:0];
    shape_ok = (hw_hi[15:4] == 12'hF84) && (hw_lo[11:6] == 6'd0);

    d        = '0;
    d.base   = hw_hi[3:0];
    d.src    = hw_lo[15:12];
    d.ofs    = hw_lo[3:0];
    d.bad    = !shape_ok || (d.base == PC_IX);
    d.unpred = !d.bad && ((d.src == PC_IX) || (d.ofs == PC_IX));
    d.pre    = 1'b1;
    d.up     = 1'b1;
    d.wb     = 1'b0;
    d.kind   = SH_LSL;
    d.amt    = {3'b000, hw_lo[5:4]};
  end
endmodule

// File: rtl/stw_shifter.sv
module stw_shifter
  import stw_regoff_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]    val,
  input  shkind_e            kind,
  input  logic [SHAMT_W-1:0] amt,
  input  logic               cin,
  output logic [XLEN-1:0]    res
);
  logic [2*XLEN-1:0] dbl;
  logic              zero_amt;

  always_comb begin
    zero_amt = (amt == '0);
    dbl      = {val, val} >> amt;
    unique case (kind)
      SH_LSL: res = val << amt;
      SH_LSR: res = zero_amt ? '0 : (val >> amt);
      SH_ASR: res = zero_amt ? {XLEN{val[XLEN-1]}} : XLEN'($signed(val) >>> amt);
      SH_ROR: res = zero_amt ? {cin, val[XLEN-1:1]} : dbl[XLEN-1:0];
      default: res = val;
    endcase
  end
endmodule

// File: rtl/stw_regoff_unit.sv
module stw_regoff_unit
  import stw_regoff_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [1:0]       fmt_sel,
  input  logic [31:0]      insn,
  input  logic             carry_in,
  input  logic [XLEN-1:0]  pc_store_val,
  output logic [3:0]       rd_base_idx,
  output logic [3:0]       rd_ofs_idx,
  output logic [3:0]       rd_src_idx,
  input  logic [XLEN-1:0]  rd_base_val,
  input  logic [XLEN-1:0]  rd_ofs_val,
  input  logic [XLEN-1:0]  rd_src_val,
  output logic             mem_we,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  output logic             wb_we,
  output logic [3:0]       wb_idx,
  output logic [XLEN-1:0]  wb_val,
  output logic             flag_undef,
  output logic             flag_alt,
  output logic             flag_unpred
);
  dec_t d_wide, d_narrow, d_pair, d_sel;

  stw_dec_wide   u_dec_wide   (.insn(insn),       .d(d_wide));
  stw_dec_narrow u_dec_narrow (.hw(insn[15:0]),   .d(d_narrow));
  stw_dec_pair   u_dec_pair   (.insn(insn),       .d(d_pair));

  always_comb begin
    unique case (fmt_sel)
      FMT_WIDE:   d_sel = d_wide;
      FMT_NARROW: d_sel = d_narrow;
      FMT_PAIR:   d_sel = d_pair;
      default: begin
        d_sel     = '0;
        d_sel.bad = 1'b1;
      end
    endcase
  end

  assign rd_base_idx = d_sel.base;
  assign rd_ofs_idx  = d_sel.ofs;
  assign rd_src_idx  = d_sel.src;

  logic [XLEN-1:0] ofs_shifted, ofs_addr, eff_addr, st_data;
  logic            go;

  stw_shifter #(.XLEN(XLEN)) u_shift (
    .val  (rd_ofs_val),
    .kind (d_sel.kind),
    .amt  (d_sel.amt),
    .cin  (carry_in),
    .res  (ofs_shifted)
  );

  always_comb begin
    ofs_addr = d_sel.up  ? (rd_base_val + ofs_shifted) : (rd_base_val - ofs_shifted);
    eff_addr = d_sel.pre ? ofs_addr : rd_base_val;
    st_data  = (d_sel.src == PC_IX) ? pc_store_val : rd_src_val;
    go       = in_valid && !d_sel.bad && !d_sel.alt && !d_sel.unpred;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
      wb_we       <= 1'b0;
      wb_idx      <= '0;
      wb_val      <= '0;
      flag_undef  <= 1'b0;
      flag_alt    <= 1'b0;
      flag_unpred <= 1'b0;
    end else begin
      mem_we      <= go;
      mem_addr    <= go ? eff_addr : '0;
      mem_wdata   <= go ? st_data  : '0;
      wb_we       <= go && d_sel.wb;
      wb_idx      <= (go && d_sel.wb) ? d_sel.base : '0;
      wb_val      <= (go && d_sel.wb) ? ofs_addr   : '0;
      flag_undef  <= in_valid && d_sel.bad;
      flag_alt    <= in_valid && d_sel.alt;
      flag_unpred <= in_valid && d_sel.unpred;
    end
  end
endmodule

// File: rtl/stw_regoff_chk.sv
module stw_regoff_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [1:0] fmt_sel,
  input logic       mem_we,
  input logic       wb_we,
  input logic [3:0] wb_idx,
  input logic       flag_undef,
  input logic       flag_alt,
  input logic       flag_unpred
);
  a_r13_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_undef, flag_alt, flag_unpred}));

  // R3 R4 R11: a flagged instruction issues no write
  a_r4_flag_blocks_write: assert property (@(posedge clk) disable iff (rst)
    (flag_undef || flag_alt || flag_unpred) |-> (!mem_we && !wb_we));

  a_r7_wb_with_store: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> mem_we);

  a_r4_wb_not_pc: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> (wb_idx != 4'hF));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!mem_we && !wb_we && !flag_undef && !flag_alt && !flag_unpred));

  a_r9_narrow_no_wb: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_sel == 2'd1) |=> !wb_we);

  a_r10_pair_no_wb: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_sel == 2'd2) |=> !wb_we);

  a_r12_fmt3_undef: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fmt_sel == 2'd3) |=> flag_undef);
endmodule

bind stw_regoff_unit stw_regoff_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .fmt_sel     (fmt_sel),
  .mem_we      (mem_we),
  .wb_we       (wb_we),
  .wb_idx      (wb_idx),
  .flag_undef  (flag_undef),
  .flag_alt    (flag_alt),
  .flag_unpred (flag_unpred)
);

// File: tb/stw_regoff_unit_tb.sv
`timescale 1ns/1ps
module stw_regoff_unit_tb;
  localparam int XLEN = 32;

  function automatic logic [31:0] enc_w(logic [3:0] c, logic p, logic u, logic w,
                                        logic [3:0] n, logic [3:0] t, logic [4:0] a,
                                        logic [1:0] k, logic [3:0] m);
    return {c, 3'b011, p, u, 1'b0, w, 1'b0, n, t, a, k, 1'b0, m};
  endfunction

  function automatic logic [31:0] enc_n(logic [2:0] m, logic [2:0] n, logic [2:0] t);
    return {16'h0000, 7'b0101000, m, n, t};
  endfunction

  function automatic logic [31:0] enc_p(logic [3:0] n, logic [3:0] t, logic [1:0] a, logic [3:0] m);
    return {12'hF84, n, t, 6'b000000, a, m};
  endfunction

  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  fmt;
    logic [31:0] insn;
    logic        cin;
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
    logic        wbwe;
    logic [3:0]  wbix;
    logic [31:0] wbv;
    logic [2:0]  flg;   // {undef, alt, unpred}
    logic [3:0]  n;
    logic [3:0]  m;
    logic [3:0]  t;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd7,  2'd0, enc_w(4'hE,1,1,0,4'd0,4'd5,5'd2,2'd0,4'd1),  1'b0, 1'b1, 32'h0000_1010, 32'hDEAD_BEEF, 1'b0, 4'd0, 32'h0,          3'b000, 4'd0, 4'd1, 4'd5},  // R7 R5 LSL
    '{4'd5,  2'd0, enc_w(4'hE,1,0,1,4'd4,4'd7,5'd4,2'd1,4'd6),  1'b0, 1'b1, 32'h0000_1FF0, 32'h1234_5678, 1'b1, 4'd4, 32'h0000_1FF0, 3'b000, 4'd4, 4'd6, 4'd7},  // R5 LSR, R7 subtract + wb
    '{4'd7,  2'd0, enc_w(4'hE,0,1,0,4'd0,4'd1,5'd1,2'd2,4'd2),  1'b0, 1'b1, 32'h0000_1000, 32'h0000_0004, 1'b1, 4'd0, 32'hC000_1008, 3'b000, 4'd0, 4'd2, 4'd1},  // R7 post-index, R5 ASR
    '{4'd6,  2'd0, enc_w(4'hE,1,1,0,4'd4,4'd3,5'd0,2'd1,4'd2),  1'b0, 1'b1, 32'h0000_2000, 32'h0000_0003, 1'b0, 4'd0, 32'h0,          3'b000, 4'd4, 4'd2, 4'd3},  // R6 LSR by 32
    '{4'd6,  2'd0, enc_w(4'hE,1,1,0,4'd4,4'd3,5'd0,2'd2,4'd2),  1'b0, 1'b1, 32'h0000_1FFF, 32'h0000_0003, 1'b0, 4'd0, 32'h0,          3'b000, 4'd4, 4'd2, 4'd3},  // R6 ASR by 32
    '{4'd6,  2'd0, enc_w(4'hE,1,1,0,4'd0,4'd6,5'd0,2'd3,4'd3),  1'b1, 1'b1, 32'h8000_1001, 32'h0000_0100, 1'b0, 4'd0, 32'h0,          3'b000, 4'd0, 4'd3, 4'd6},  // R6 rotate through carry
    '{4'd5,  2'd0, enc_w(4'hE,1,1,0,4'd0,4'd6,5'd4,2'd3,4'd7),  1'b1, 1'b1, 32'h8123_5567, 32'h0000_0100, 1'b0, 4'd0, 32'h0,          3'b000, 4'd0, 4'd7, 4'd6},  // R5 ROR
    '{4'd8,  2'd0, enc_w(4'hE,1,1,0,4'd0,4'd15,5'd0,2'd0,4'd1), 1'b0, 1'b1, 32'h0000_1004, 32'h0000_8008, 1'b0, 4'd0, 32'h0,          3'b000, 4'd0, 4'd1, 4'd15}, // R8 pc data
    '{4'd3,  2'd0, enc_w(4'hE,0,1,1,4'd0,4'd1,5'd0,2'd0,4'd1),  1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b010, 4'd0, 4'd0, 4'd0},  // R3 alt variant
    '{4'd4,  2'd0, enc_w(4'hE,1,1,0,4'd0,4'd1,5'd0,2'd0,4'd15), 1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b001, 4'd0, 4'd0, 4'd0},  // R4 offset reg 15
    '{4'd4,  2'd0, enc_w(4'hE,1,1,1,4'd4,4'd4,5'd0,2'd0,4'd1),  1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b001, 4'd0, 4'd0, 4'd0},  // R4 base == source
    '{4'd4,  2'd0, enc_w(4'hE,0,1,0,4'd15,4'd1,5'd0,2'd0,4'd1), 1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b001, 4'd0, 4'd0, 4'd0},  // R4 base 15 with wb
    '{4'd13, 2'd0, enc_w(4'hF,1,1,0,4'd0,4'd1,5'd0,2'd0,4'd15), 1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b100, 4'd0, 4'd0, 4'd0},  // R13 R2 cond 1111 only undef
    '{4'd2,  2'd0, enc_w(4'hE,1,1,0,4'd0,4'd1,5'd0,2'd0,4'd1) | 32'h10, 1'b0, 1'b0, 32'h0, 32'h0,          1'b0, 4'd0, 32'h0,          3'b100, 4'd0, 4'd0, 4'd0},  // R2 bit 4 set
    '{4'd7,  2'd0, enc_w(4'hE,1,0,0,4'd0,4'd1,5'd31,2'd0,4'd3), 1'b0, 1'b1, 32'h8000_1000, 32'h0000_0004, 1'b0, 4'd0, 32'h0,          3'b000, 4'd0, 4'd3, 4'd1},  // R7 subtract, LSL 31
    '{4'd2,  2'd0, enc_w(4'h0,1,1,1,4'd8,4'd2,5'd0,2'd0,4'd1),  1'b0, 1'b1, 32'h0000_0204, 32'h8000_0010, 1'b1, 4'd8, 32'h0000_0204, 3'b000, 4'd8, 4'd1, 4'd2},  // R2 pre-index + wb, cond 0000
    '{4'd9,  2'd1, {16'hABCD, 16'h0000} | enc_n(3'd1,3'd0,3'd5), 1'b0, 1'b1, 32'h0000_1004, 32'hDEAD_BEEF, 1'b0, 4'd0, 32'h0,   3'b000, 4'd0, 4'd1, 4'd5},  // R9 upper bits ignored
    '{4'd9,  2'd1, enc_n(3'd3,3'd4,3'd7),                      1'b1, 1'b1, 32'h0000_2003, 32'h1234_5678, 1'b0, 4'd0, 32'h0,          3'b000, 4'd4, 4'd3, 4'd7},  // R9
    '{4'd9,  2'd1, 32'h0000_5200,                              1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b100, 4'd0, 4'd0, 4'd0},  // R9 bad pattern
    '{4'd10, 2'd2, enc_p(4'd0,4'd5,2'd3,4'd1),                 1'b0, 1'b1, 32'h0000_1020, 32'hDEAD_BEEF, 1'b0, 4'd0, 32'h0,          3'b000, 4'd0, 4'd1, 4'd5},  // R10 shift 3
    '{4'd10, 2'd2, enc_p(4'd8,4'd14,2'd0,4'd6),                1'b0, 1'b1, 32'h0000_0300, 32'h0000_0380, 1'b0, 4'd0, 32'h0,          3'b000, 4'd8, 4'd6, 4'd14}, // R10 high regs
    '{4'd11, 2'd2, enc_p(4'd15,4'd1,2'd0,4'd1),                1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b100, 4'd0, 4'd0, 4'd0},  // R11 base 1111
    '{4'd11, 2'd2, enc_p(4'd0,4'd15,2'd0,4'd1),                1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b001, 4'd0, 4'd0, 4'd0},  // R11 source 15
    '{4'd11, 2'd2, enc_p(4'd0,4'd1,2'd0,4'd15),                1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b001, 4'd0, 4'd0, 4'd0},  // R11 offset 15
    '{4'd10, 2'd2, enc_p(4'd0,4'd1,2'd0,4'd1) | 32'h40,        1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b100, 4'd0, 4'd0, 4'd0},  // R10 zero field
    '{4'd12, 2'd3, enc_w(4'hE,1,1,0,4'd0,4'd5,5'd2,2'd0,4'd1),  1'b0, 1'b0, 32'h0,         32'h0,          1'b0, 4'd0, 32'h0,          3'b100, 4'd0, 4'd0, 4'd0}   // R12
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic [1:0]       fmt_sel;
  logic [31:0]      insn;
  logic             carry_in;
  logic [XLEN-1:0]  pc_store_val;
  logic [3:0]       rd_base_idx, rd_ofs_idx, rd_src_idx;
  logic [XLEN-1:0]  rd_base_val, rd_ofs_val, rd_src_val;
  logic             mem_we, wb_we, flag_undef, flag_alt, flag_unpred;
  logic [XLEN-1:0]  mem_addr, mem_wdata, wb_val;
  logic [3:0]       wb_idx;
  logic [XLEN-1:0]  rf [16];

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign rd_base_val = rf[rd_base_idx];
  assign rd_ofs_val  = rf[rd_ofs_idx];
  assign rd_src_val  = rf[rd_src_idx];

  stw_regoff_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel), .insn(insn),
    .carry_in(carry_in), .pc_store_val(pc_store_val),
    .rd_base_idx(rd_base_idx), .rd_ofs_idx(rd_ofs_idx), .rd_src_idx(rd_src_idx),
    .rd_base_val(rd_base_val), .rd_ofs_val(rd_ofs_val), .rd_src_val(rd_src_val),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wb_we(wb_we), .wb_idx(wb_idx), .wb_val(wb_val),
    .flag_undef(flag_undef), .flag_alt(flag_alt), .flag_unpred(flag_unpred)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_quiet(string tag);
    check(tag, {27'd0, mem_we, wb_we, flag_undef, flag_alt, flag_unpred}, 32'd0);
    check(tag, mem_addr | mem_wdata | wb_val, 32'd0);
  endtask

  initial begin
    rf[0] = 32'h0000_1000; rf[1] = 32'h0000_0004; rf[2] = 32'h8000_0010; rf[3] = 32'h0000_0003;
    rf[4] = 32'h0000_2000; rf[5] = 32'hDEAD_BEEF; rf[6] = 32'h0000_0100; rf[7] = 32'h1234_5678;
    for (int k = 8; k < 15; k++) rf[k] = 32'h40 * k;
    rf[15] = 32'hFFFF_FFFF;
    pc_store_val = 32'h0000_8008;
    rst = 1'b1; in_valid = 1'b1; fmt_sel = 2'd0; carry_in = 1'b0;
    insn = enc_w(4'hE,1,1,0,4'd0,4'd5,5'd2,2'd0,4'd1);
    repeat (3) @(negedge clk);
    check_quiet("R1 reset holds outputs low");
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check_quiet("R1 idle after reset");

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VEC[i].req, i);
      in_valid = 1'b1;
      fmt_sel  = VEC[i].fmt;
      insn     = VEC[i].insn;
      carry_in = VEC[i].cin;
      #1;
      if (VEC[i].we) begin
        // R14: read indices are combinational
        check({tg, " R14 idx"}, {20'd0, rd_base_idx, rd_ofs_idx, rd_src_idx},
              {20'd0, VEC[i].n, VEC[i].m, VEC[i].t});
      end
      @(negedge clk);
      check({tg, " we"},    {31'd0, mem_we}, {31'd0, VEC[i].we});
      check({tg, " addr"},  mem_addr,  VEC[i].addr);
      check({tg, " data"},  mem_wdata, VEC[i].data);
      check({tg, " wb"},    {27'd0, wb_we, wb_idx}, {27'd0, VEC[i].wbwe, VEC[i].wbix});
      check({tg, " wbval"}, wb_val, VEC[i].wbv);
      check({tg, " flags"}, {29'd0, flag_undef, flag_alt, flag_unpred}, {29'd0, VEC[i].flg});
    end

    // R1: one-cycle latency, then quiet once in_valid drops
    fmt_sel = 2'd0;
    insn = enc_w(4'hE,1,1,1,4'd8,4'd2,5'd0,2'd0,4'd1);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 latency one edge", {31'd0, wb_we}, 32'd1);
    @(negedge clk);
    check_quiet("R1 quiet after in_valid low");

    // R1: reset in the middle of a stream
    in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_quiet("R1 mid-run reset");
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule